// File: doc/BRIEF.md
# Recoverable Fault Status Bank

This block is the input stage of a fault supervisor. It takes two groups of raw fault lines, critical and non-critical, each four words of 32 bits by default. It passes every line through a two-flop synchroniser and keeps one status bit per line. Each status bit follows one of two recovery policies, chosen per bit by a configuration word.

- **Hardware-recovered bits** mirror the synchronised level. They drop by themselves once the cause goes away.
- **Software-recovered bits** catch a pulse of any length and hold it until software clears it.

A small register port is used for four things:

- writing the configuration words;
- arming a one-shot clear key;
- clearing held bits with write-one-to-clear;
- injecting a fake fault by its flat index.

The flat status vectors feed the supervisor state machine directly.

Register map (address on `wr_addr`):

- 0–3: critical configuration words.
- 4–7: non-critical configuration words.
- 8–11: critical status words.
- 12–15: non-critical status words.
- 16: key register.
- 17: critical fake-fault index.
- 18: non-critical fake-fault index.

Status word w covers flat bits 32w+31 down to 32w.

Top module: `fault_status_bank`

## Requirements
- R1: A raw fault input that rises is first visible on its status bit after the third rising clock edge that samples it; after two edges the bit is still clear.
- R2: A bit whose configuration bit is 0 (hardware recovery) follows the synchronised input. Once the input falls, the bit clears after the same three-edge latency, with no write.
- R3: A bit whose configuration bit is 1 (software recovery) latches an input pulse as short as one cycle. It stays set until cleared by a keyed write.
- R4: After reset all configuration words are 0 (hardware recovery). Configuration words are written at addresses 0–3 (critical) and 4–7 (non-critical).
- R5: Writing the key value 32'hC3A5_5A3C to address 16 arms exactly one following status write. A status write to addresses 8–11 (critical) or 12–15 (non-critical) clears every software-recovered bit written with a one, and disarms the key.
- R6: A status write made while the key is not armed changes no status bit. `key_err` is high for exactly the one cycle after that write.
- R7: A keyed clear has no effect on a hardware-recovered bit whose input is still high.
- R8: If a clear and a fault event hit the same bit in the same cycle, the bit stays set.
- R9: Writing index n to address 17 (critical) or 18 (non-critical) acts as a one-cycle event on flat bit n. That is bit n%32 of status word n/32. It shows on the status output after the write's clock edge: it is held for a software-recovered bit and high for one cycle for a hardware-recovered bit.
- R10: A fake-fault write whose data value is 128 or larger sets no status bit.
- R11: During and after reset both status vectors and `key_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_in | input | 128 | Raw critical fault lines, active high |
| ncrit_in | input | 128 | Raw non-critical fault lines, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| crit_status | output | 128 | Critical status vector |
| ncrit_status | output | 128 | Non-critical status vector |
| key_err | output | 1 | One-cycle flag for an unkeyed status write |

## Verification
The assertions are checked on every cycle:

- A hardware-recovered bit always matches the event of the previous cycle.
- A software-recovered bit never drops unless a clear mask covered it.
- No status bit rises without an event.
- `key_err` only follows an unarmed status write, and never follows an armed one.

Only the bench scenarios show the following:

- the exact three-edge synchroniser latency;
- the one-shot life of the key across unrelated writes;
- the index-to-word mapping, and rejection of out-of-range indices;
- the clear-versus-event collision;
- the reset default of hardware recovery.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;

    localparam int FS_WORDS  = 4;
    localparam int FS_WORD_W = 32;
    localparam logic [31:0] FS_CLEAR_KEY = 32'hC3A5_5A3C;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CFG_CRIT,
        RGN_CFG_NCRIT,
        RGN_ST_CRIT,
        RGN_ST_NCRIT,
        RGN_KEY,
        RGN_FAKE_CRIT,
        RGN_FAKE_NCRIT
    } fs_region_e;

    function automatic fs_region_e decode_region(input int addr, input int nw);
        fs_region_e r;
        if (addr < nw)              r = RGN_CFG_CRIT;
        else if (addr < 2 * nw)     r = RGN_CFG_NCRIT;
        else if (addr < 3 * nw)     r = RGN_ST_CRIT;
        else if (addr < 4 * nw)     r = RGN_ST_NCRIT;
        else if (addr == 4 * nw)    r = RGN_KEY;
        else if (addr == 4 * nw + 1) r = RGN_FAKE_CRIT;
        else if (addr == 4 * nw + 2) r = RGN_FAKE_NCRIT;
        else                        r = RGN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fault_reg_decode.sv
module fault_reg_decode
    import fault_status_pkg::*;
#(
    parameter int          NUM_WORDS = FS_WORDS,
    parameter int          WORD_W    = FS_WORD_W,
    parameter logic [31:0] CLEAR_KEY = FS_CLEAR_KEY,
    localparam int         TOTAL     = NUM_WORDS * WORD_W,
    localparam int         IDX_W     = $clog2(TOTAL),
    localparam int         ADDR_W    = $clog2(4 * NUM_WORDS + 3)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [NUM_WORDS-1:0] crit_cfg_we,
    output logic [NUM_WORDS-1:0] ncrit_cfg_we,
    output logic [NUM_WORDS-1:0] crit_clr_we,
    output logic [NUM_WORDS-1:0] ncrit_clr_we,
    output logic [TOTAL-1:0]     crit_fake,
    output logic [TOTAL-1:0]     ncrit_fake,
    output logic                 st_write,
    output logic                 armed,
    output logic                 key_err
);
    fs_region_e region;
    int         word_sel;
    logic       idx_ok;
    logic [TOTAL-1:0] onehot;

    always_comb begin
        region   = wr_en ? decode_region(int'(wr_addr), NUM_WORDS) : RGN_NONE;
        word_sel = int'(wr_addr) % NUM_WORDS;
        idx_ok   = (wr_data < WORD_W'(TOTAL));
        onehot   = TOTAL'(1) << wr_data[IDX_W-1:0];
        st_write = (region == RGN_ST_CRIT) || (region == RGN_ST_NCRIT);
    end

    assign crit_fake  = (region == RGN_FAKE_CRIT  && idx_ok) ? onehot : '0;
    assign ncrit_fake = (region == RGN_FAKE_NCRIT && idx_ok) ? onehot : '0;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word_we
        assign crit_cfg_we[w]  = (region == RGN_CFG_CRIT)  && (word_sel == w);
        assign ncrit_cfg_we[w] = (region == RGN_CFG_NCRIT) && (word_sel == w);
        assign crit_clr_we[w]  = (region == RGN_ST_CRIT)   && (word_sel == w) && armed;
        assign ncrit_clr_we[w] = (region == RGN_ST_NCRIT)  && (word_sel == w) && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            key_err <= 1'b0;
        end else begin
            if (region == RGN_KEY)
                armed <= (wr_data == WORD_W'(CLEAR_KEY));
            else if (st_write)
                armed <= 1'b0;
            key_err <= st_write && !armed;
        end
    end
endmodule

// File: rtl/fault_word_bank.sv
module fault_word_bank #(
    parameter int  NUM_WORDS = 4,
    parameter int  WORD_W    = 32,
    localparam int TOTAL     = NUM_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TOTAL-1:0]     ev,
    input  logic [TOTAL-1:0]     clr,
    input  logic [NUM_WORDS-1:0] cfg_we,
    input  logic [WORD_W-1:0]    cfg_data,
    output logic [TOTAL-1:0]     mode,
    output logic [TOTAL-1:0]     status
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] mode_q;
        logic [WORD_W-1:0] st_q;
        logic [WORD_W-1:0] ev_w;
        logic [WORD_W-1:0] clr_w;

        assign ev_w  = ev[w*WORD_W +: WORD_W];
        assign clr_w = clr[w*WORD_W +: WORD_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q <= '0;
                st_q   <= '0;
            end else begin
                if (cfg_we[w])
                    mode_q <= cfg_data;
                // an event always wins; only software-recovered bits keep state
                st_q <= ev_w | (mode_q & st_q & ~clr_w);
            end
        end

        assign mode[w*WORD_W +: WORD_W]   = mode_q;
        assign status[w*WORD_W +: WORD_W] = st_q;
    end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
    import fault_status_pkg::*;
#(
    parameter int          NUM_WORDS = FS_WORDS,
    parameter int          WORD_W    = FS_WORD_W,
    parameter logic [31:0] CLEAR_KEY = FS_CLEAR_KEY,
    localparam int         TOTAL     = NUM_WORDS * WORD_W,
    localparam int         ADDR_W    = $clog2(4 * NUM_WORDS + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TOTAL-1:0]  crit_in,
    input  logic [TOTAL-1:0]  ncrit_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [TOTAL-1:0]  crit_status,
    output logic [TOTAL-1:0]  ncrit_status,
    output logic              key_err
);
    logic [TOTAL-1:0]     crit_sync, ncrit_sync;
    logic [TOTAL-1:0]     crit_fake, ncrit_fake;
    logic [TOTAL-1:0]     crit_ev, ncrit_ev;
    logic [TOTAL-1:0]     crit_clr, ncrit_clr;
    logic [TOTAL-1:0]     crit_mode, ncrit_mode;
    logic [NUM_WORDS-1:0] crit_cfg_we, ncrit_cfg_we;
    logic [NUM_WORDS-1:0] crit_clr_we, ncrit_clr_we;
    logic                 st_write, armed;

    fault_sync #(.WIDTH(TOTAL)) u_sync_crit  (.clk(clk), .rst(rst), .d(crit_in),  .q(crit_sync));
    fault_sync #(.WIDTH(TOTAL)) u_sync_ncrit (.clk(clk), .rst(rst), .d(ncrit_in), .q(ncrit_sync));

    fault_reg_decode #(
        .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .CLEAR_KEY(CLEAR_KEY)
    ) u_decode (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .crit_cfg_we(crit_cfg_we), .ncrit_cfg_we(ncrit_cfg_we),
        .crit_clr_we(crit_clr_we), .ncrit_clr_we(ncrit_clr_we),
        .crit_fake(crit_fake), .ncrit_fake(ncrit_fake),
        .st_write(st_write), .armed(armed), .key_err(key_err)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
        assign crit_clr[w*WORD_W +: WORD_W]  = crit_clr_we[w]  ? wr_data : '0;
        assign ncrit_clr[w*WORD_W +: WORD_W] = ncrit_clr_we[w] ? wr_data : '0;
    end

    assign crit_ev  = crit_sync  | crit_fake;
    assign ncrit_ev = ncrit_sync | ncrit_fake;

    fault_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank_crit (
        .clk(clk), .rst(rst), .ev(crit_ev), .clr(crit_clr),
        .cfg_we(crit_cfg_we), .cfg_data(wr_data),
        .mode(crit_mode), .status(crit_status)
    );

    fault_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank_ncrit (
        .clk(clk), .rst(rst), .ev(ncrit_ev), .clr(ncrit_clr),
        .cfg_we(ncrit_cfg_we), .cfg_data(wr_data),
        .mode(ncrit_mode), .status(ncrit_status)
    );
endmodule

// File: rtl/fault_status_checks.sv
module fault_status_checks #(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] mode,
    input logic [W-1:0] ev,
    input logic [W-1:0] clr,
    input logic [W-1:0] st,
    input logic         st_write,
    input logic         armed,
    input logic         key_err
);
    assert_hw_follows_R2: assert property (@(posedge clk) disable iff (rst)
        ((st ^ $past(ev)) & ~$past(mode)) == '0);

    assert_sw_holds_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(st & mode & ~clr) & ~st) == '0);

    assert_set_by_event_R9: assert property (@(posedge clk) disable iff (rst)
        ((st & ~$past(st)) & ~$past(ev)) == '0);

    assert_keyerr_cause_R6: assert property (@(posedge clk) disable iff (rst)
        key_err |-> $past(st_write && !armed));

    assert_armed_no_err_R5: assert property (@(posedge clk) disable iff (rst)
        (st_write && armed) |=> !key_err);
endmodule

bind fault_status_bank fault_status_checks #(.W(2 * TOTAL)) u_checks (
    .clk(clk), .rst(rst),
    .mode({crit_mode, ncrit_mode}),
    .ev({crit_ev, ncrit_ev}),
    .clr({crit_clr, ncrit_clr}),
    .st({crit_status, ncrit_status}),
    .st_write(st_write), .armed(armed), .key_err(key_err)
);

// File: tb/tb_fault_status_bank.sv
module tb_fault_status_bank;
    localparam int          TOT = 128;
    localparam logic [31:0] KEY = 32'hC3A5_5A3C;
    localparam int          NV  = 8;
    // bit 32: 0 = critical, 1 = non-critical; bits 31:0: index written
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 32'd20}, {1'b1, 32'd12}, {1'b0, 32'd0},   {1'b0, 32'd127},
        {1'b1, 32'd63}, {1'b0, 32'd128}, {1'b1, 32'd200}, {1'b0, 32'h8000_0014}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [TOT-1:0] crit_in = '0, ncrit_in = '0;
    logic           wr_en = 1'b0;
    logic [4:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [TOT-1:0] crit_status, ncrit_status;
    logic           key_err;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    fault_status_bank dut (
        .clk(clk), .rst(rst), .crit_in(crit_in), .ncrit_in(ncrit_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .crit_status(crit_status), .ncrit_status(ncrit_status), .key_err(key_err)
    );

    task automatic check(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all(input logic ncls);
        for (int w = 0; w < 4; w++) begin
            wr(5'd16, KEY);
            wr(ncls ? 5'(12 + w) : 5'(8 + w), 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        check("R11 crit reset", crit_status, '0);
        check("R11 ncrit reset", ncrit_status, '0);
        check("R11 key_err reset", TOT'(key_err), '0);
        rst = 1'b0;
        tick(1);

        // R4: reset default is hardware recovery, so a fake event lasts one cycle
        wr(5'd18, 32'd12);
        check("R4 R9 hw fake set", ncrit_status, TOT'(1) << 12);
        tick(1);
        check("R4 hw fake gone", ncrit_status, '0);

        for (int w = 0; w < 8; w++) wr(5'(w), 32'hFFFF_FFFF);

        // table: fake-index injection onto software-recovered bits (R9, R10)
        for (int i = 0; i < NV; i++) begin
            logic [TOT-1:0] exp;
            exp = (VEC[i][31:0] < 32'd128) ? (TOT'(1) << VEC[i][6:0]) : '0;
            wr(VEC[i][32] ? 5'd18 : 5'd17, VEC[i][31:0]);
            tick(1);
            if (VEC[i][32]) begin
                check("R9 R10 ncrit fake", ncrit_status, exp);
                check("R9 crit untouched", crit_status, '0);
            end else begin
                check("R9 R10 crit fake", crit_status, exp);
                check("R9 ncrit untouched", ncrit_status, '0);
            end
            clear_all(VEC[i][32]);
            check("R5 cleared crit", crit_status, '0);
            check("R5 cleared ncrit", ncrit_status, '0);
        end

        // R1 / R3: one-cycle pulse on bit 5, three-edge latency, then held
        crit_in[5] = 1'b1; tick(1); crit_in[5] = 1'b0; tick(1);
        check("R1 not yet", crit_status, '0);
        tick(1);
        check("R1 visible", crit_status, TOT'(1) << 5);
        tick(5);
        check("R3 held", crit_status, TOT'(1) << 5);

        // R6: unkeyed status write ignored, one-cycle error
        wr(5'd8, 32'h20);
        check("R6 key_err", TOT'(key_err), TOT'(1));
        check("R6 status kept", crit_status, TOT'(1) << 5);
        tick(1);
        check("R6 key_err gone", TOT'(key_err), '0);

        // R5: key is consumed by one status write
        wr(5'd16, KEY);
        wr(5'd9, 32'h0);
        wr(5'd8, 32'h20);
        check("R5 one-shot err", TOT'(key_err), TOT'(1));
        check("R5 one-shot kept", crit_status, TOT'(1) << 5);
        wr(5'd16, KEY);
        wr(5'd8, 32'h20);
        check("R5 keyed clear", crit_status, '0);
        check("R5 no err", TOT'(key_err), '0);

        // R8: clear collides with a live event
        crit_in[3] = 1'b1; tick(3);
        check("R8 set", crit_status, TOT'(1) << 3);
        wr(5'd16, KEY);
        wr(5'd8, 32'h8);
        check("R8 stays set", crit_status, TOT'(1) << 3);
        crit_in[3] = 1'b0; tick(4);
        check("R8 latched", crit_status, TOT'(1) << 3);
        wr(5'd16, KEY);
        wr(5'd8, 32'h8);
        check("R8 cleared", crit_status, '0);

        // R7 / R2: word 1 hardware recovery
        wr(5'd1, 32'h0);
        crit_in[40] = 1'b1; tick(3);
        check("R2 hw set", crit_status, TOT'(1) << 40);
        wr(5'd16, KEY);
        wr(5'd9, 32'hFFFF_FFFF);
        check("R7 clear no effect", crit_status, TOT'(1) << 40);
        crit_in[40] = 1'b0; tick(2);
        check("R2 still high", crit_status, TOT'(1) << 40);
        tick(1);
        check("R2 dropped", crit_status, '0);
        wr(5'd17, 32'd40);
        check("R9 hw fake pulse", crit_status, TOT'(1) << 40);
        tick(1);
        check("R9 hw fake gone", crit_status, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule